// File: doc/BRIEF.md
# Fetch Next-PC Predictor with Target Table and Return Stack

This block produces the address to fetch after the current one, in the same cycle that the fetch address is presented. It combines a direct-mapped target table with a small return-address stack. The table is indexed by word address bits of the fetch PC. Each slot holds a valid bit, a taken indication, the complete branch PC and that branch's target. A slot's target is used only when the complete stored PC equals the fetch PC, so an aliased branch never steers fetch. Returns are predicted from the stack and never from the table. Calls push the address of the instruction after the call.

Resolved branches come back through a separate update port. A taken resolution writes or overwrites the slot. A not-taken resolution clears the slot, provided the slot still belongs to that branch.

The return stack is governed by a three-state controller. The states are STK_EMPTY, STK_PARTIAL and STK_FULL, and the transitions are:
- STK_EMPTY to STK_PARTIAL on a push.
- STK_PARTIAL to STK_FULL on a push that fills the last slot.
- STK_PARTIAL to STK_EMPTY on a pop of the last entry.
- STK_FULL to STK_PARTIAL on a pop.
- STK_FULL to STK_FULL on a push, which overwrites the oldest entry.
- STK_EMPTY to STK_EMPTY on a pop, which has no effect.

Top module: `bpr_next_pc`

## Requirements
- R1: After reset every table slot is invalid and the stack is empty. Any fetch then predicts fetch_pc+4 with pred_src=0 (sequential).
- R2: When the table has no matching slot for a non-return fetch, the prediction is fetch_pc+4 with pred_src=0.
- R3: When the slot indexed by fetch_pc[7:2] is valid, marked taken and holds exactly fetch_pc, a non-return fetch predicts the stored target with pred_src=1, combinationally in the same cycle.
- R4: When the indexed slot holds a different PC with the same index bits, the fetch is treated as a miss and predicts fetch_pc+4.
- R5: A taken update (upd_valid=1, upd_taken=1) writes the PC and target into the indexed slot, replacing any previous occupant. The new contents are visible to fetches from the next cycle on.
- R6: A not-taken update invalidates the indexed slot only when that slot holds upd_pc. A slot holding another branch is left intact.
- R7: A valid return fetch with a non-empty stack predicts the most recently pushed address with pred_src=2 and pops it in that cycle. This happens even if the table would hit, and successive returns come back in last-in first-out order.
- R8: A valid call fetch pushes fetch_pc+4. The call's own prediction still comes from the table or from the sequential path.
- R9: The stack holds 8 entries. A push while full overwrites the oldest entry, so after 9 calls, 8 returns yield the 8 newest addresses and the next return finds the stack empty.
- R10: A valid return fetch with an empty stack predicts fetch_pc+4 with pred_src=0, even on a table hit, and leaves the stack empty.
- R11: When an update and a fetch address the same slot in the same cycle, the fetch is predicted from the slot's contents before the update.
- R12: A fetch flagged as both call and return performs only the pop; nothing is pushed.
- R13: While fetch_valid=0, the call and return flags leave the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_pc | input | 32 | Current fetch address |
| fetch_is_call | input | 1 | Fetched instruction is a call |
| fetch_is_ret | input | 1 | Fetched instruction is a return |
| upd_valid | input | 1 | A branch resolution is presented |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_target | input | 32 | Resolved target of the branch |
| upd_taken | input | 1 | 1 = resolved taken, 0 = resolved not taken |
| pred_npc | output | 32 | Predicted next fetch address |
| pred_src | output | 2 | Source of prediction: 0 sequential, 1 table, 2 stack |

## Verification
Two functions can coincide in one cycle: a fetch lookup, and an update that rewrites the same table slot. The bench provokes this by presenting a taken update for a branch PC while fetching that same PC. It expects the sequential prediction in that cycle and the new target one cycle later. A second collision is a return fetch that would also hit in the table. The bench installs a table entry at a return's PC, then checks that the stack supplies the prediction while entries remain. Once the stack is empty, the bench checks that the prediction falls back to sequential rather than to the table.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

    typedef enum logic [1:0] {
        SRC_SEQ   = 2'd0,
        SRC_TABLE = 2'd1,
        SRC_STACK = 2'd2
    } npc_src_e;

    typedef enum logic [1:0] {
        STK_EMPTY   = 2'd0,
        STK_PARTIAL = 2'd1,
        STK_FULL    = 2'd2
    } stk_state_e;

    localparam int unsigned INSN_BYTES = 4;

endpackage

// File: rtl/bpr_target_table.sv
module bpr_target_table #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic [ADDR_W-1:0] wr_target,
    input  logic              wr_taken
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned IDX_LO = 2;

    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] dir_q;
    logic [ADDR_W-1:0]  tag_q [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_owns;

    assign lk_idx  = lk_pc[IDX_LO +: IDX_W];
    assign wr_idx  = wr_pc[IDX_LO +: IDX_W];
    assign wr_owns = vld_q[wr_idx] && (tag_q[wr_idx] == wr_pc);

    // Valid and direction bits: reset, install, or invalidate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            if (wr_taken) begin
                vld_q[wr_idx] <= 1'b1;
                dir_q[wr_idx] <= 1'b1;
            end else if (wr_owns) begin
                vld_q[wr_idx] <= 1'b0;
                dir_q[wr_idx] <= 1'b0;
            end
        end
    end

    // Payload storage needs no reset: guarded by the valid bit
    always_ff @(posedge clk) begin
        if (wr_en && wr_taken) begin
            tag_q[wr_idx] <= wr_pc;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    always_comb begin
        lk_hit    = vld_q[lk_idx] && dir_q[lk_idx] && (tag_q[lk_idx] == lk_pc);
        lk_target = tgt_q[lk_idx];
    end

    AST_TAKEN_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken |=> vld_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_pc))); // R5

    AST_NT_CLEARS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && wr_owns |=> !vld_q[$past(wr_idx)]); // R6

    AST_NT_SPARES_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && !wr_owns |=> $stable(vld_q)); // R6

endmodule

// File: rtl/bpr_return_stack.sv
module bpr_return_stack
    import bpr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [ADDR_W-1:0] top_addr,
    output logic              empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    stk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] wp_q, wp_d;
    logic [PTR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] mem_q [DEPTH];

    logic do_push, do_pop;

    assign rd_ptr  = (wp_q == '0) ? PTR_LAST : wp_q - 1'b1;
    assign do_pop  = pop && (state_q != STK_EMPTY);
    assign do_push = push && !pop;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STK_EMPTY: begin
                if (do_push) state_d = (DEPTH == 1) ? STK_FULL : STK_PARTIAL;
            end
            STK_PARTIAL: begin
                if (do_push && cnt_q == CNT_FULL - 1'b1) state_d = STK_FULL;
                else if (do_pop && cnt_q == CNT_W'(1)) state_d = STK_EMPTY;
            end
            STK_FULL: begin
                if (do_pop) state_d = (DEPTH == 1) ? STK_EMPTY : STK_PARTIAL;
            end
            default: state_d = STK_EMPTY;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        wp_d  = wp_q;
        if (do_push) begin
            wp_d = (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
            if (state_q != STK_FULL) cnt_d = cnt_q + 1'b1;
        end else if (do_pop) begin
            wp_d  = rd_ptr;
            cnt_d = cnt_q - 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STK_EMPTY;
            cnt_q   <= '0;
            wp_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wp_q    <= wp_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wp_q] <= push_addr;
    end

    // Outputs
    always_comb begin
        empty    = (state_q == STK_EMPTY);
        top_addr = mem_q[rd_ptr];
    end

    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == STK_EMPTY && pop |=> state_q == STK_EMPTY); // R10

    AST_FULL_PUSH_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == STK_FULL && push && !pop |=> state_q == STK_FULL); // R9

    AST_FULL_MATCHES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == STK_FULL |-> cnt_q == CNT_FULL); // R9

    AST_PUSH_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |=> top_addr == $past(push_addr) && !empty); // R8

endmodule

// File: rtl/bpr_next_pc.sv
module bpr_next_pc
    import bpr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned TBL_ENTRIES = 64,
    parameter int unsigned STK_DEPTH   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              fetch_is_call,
    input  logic              fetch_is_ret,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken,
    output logic [ADDR_W-1:0] pred_npc,
    output logic [1:0]        pred_src
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] seq_pc;
    logic              tbl_hit;
    logic [ADDR_W-1:0] tbl_target;
    logic [ADDR_W-1:0] stk_top;
    logic              stk_empty;
    logic              ret_now;
    logic              call_now;
    npc_src_e          src;

    assign seq_pc   = fetch_pc + STEP;
    assign ret_now  = fetch_valid && fetch_is_ret;
    assign call_now = fetch_valid && fetch_is_call && !fetch_is_ret;

    bpr_target_table #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (TBL_ENTRIES)
    ) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (fetch_pc),
        .lk_hit    (tbl_hit),
        .lk_target (tbl_target),
        .wr_en     (upd_valid),
        .wr_pc     (upd_pc),
        .wr_target (upd_target),
        .wr_taken  (upd_taken)
    );

    bpr_return_stack #(
        .ADDR_W (ADDR_W),
        .DEPTH  (STK_DEPTH)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (call_now),
        .push_addr (seq_pc),
        .pop       (ret_now),
        .top_addr  (stk_top),
        .empty     (stk_empty)
    );

    // Prediction select: return stack, then table, then sequential
    always_comb begin
        if (ret_now) begin
            src = stk_empty ? SRC_SEQ : SRC_STACK;
        end else if (tbl_hit) begin
            src = SRC_TABLE;
        end else begin
            src = SRC_SEQ;
        end
        unique case (src)
            SRC_STACK: pred_npc = stk_top;
            SRC_TABLE: pred_npc = tbl_target;
            default:   pred_npc = seq_pc;
        endcase
        pred_src = src;
    end

    AST_RET_USES_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && fetch_is_ret && !stk_empty |-> pred_npc == stk_top); // R7

    AST_RET_EMPTY_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && fetch_is_ret && stk_empty |-> pred_npc == fetch_pc + STEP); // R10

    AST_IDLE_STACK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> $stable(stk_empty) && $stable(stk_top)); // R13

    AST_BOTH_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && fetch_is_ret && fetch_is_call && stk_empty |=> stk_empty); // R12

endmodule

// File: tb/bpr_next_pc_tb.sv
module bpr_next_pc_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_valid, fetch_is_call, fetch_is_ret;
    logic [31:0] fetch_pc;
    logic        upd_valid, upd_taken;
    logic [31:0] upd_pc, upd_target;
    logic [31:0] pred_npc;
    logic [1:0]  pred_src;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    bpr_next_pc u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid   (fetch_valid),
        .fetch_pc      (fetch_pc),
        .fetch_is_call (fetch_is_call),
        .fetch_is_ret  (fetch_is_ret),
        .upd_valid     (upd_valid),
        .upd_pc        (upd_pc),
        .upd_target    (upd_target),
        .upd_taken     (upd_taken),
        .pred_npc      (pred_npc),
        .pred_src      (pred_src)
    );

    task automatic idle_inputs();
        fetch_valid = 1'b0; fetch_pc = '0; fetch_is_call = 1'b0; fetch_is_ret = 1'b0;
        upd_valid = 1'b0; upd_pc = '0; upd_target = '0; upd_taken = 1'b0;
    endtask

    task automatic judge(input logic [31:0] exp_npc, input logic [1:0] exp_src, input string req);
        checks++;
        if (pred_npc !== exp_npc || pred_src !== exp_src) begin
            failures++;
            $display("FAIL %s: npc=%h src=%0d expected npc=%h src=%0d",
                     req, pred_npc, pred_src, exp_npc, exp_src);
        end
    endtask

    // One cycle: drive after the falling edge, check before the rising edge
    task automatic cyc(input logic fv, input logic [31:0] pc, input logic call, input logic ret,
                       input logic uv, input logic [31:0] upc, input logic [31:0] utgt,
                       input logic utk, input logic chk, input logic [31:0] exp_npc,
                       input logic [1:0] exp_src, input string req);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; fetch_is_call = call; fetch_is_ret = ret;
        upd_valid = uv; upd_pc = upc; upd_target = utgt; upd_taken = utk;
        #1;
        if (chk) judge(exp_npc, exp_src, req);
    endtask

    task automatic fetch(input logic [31:0] pc, input logic call, input logic ret,
                         input logic [31:0] exp_npc, input logic [1:0] exp_src, input string req);
        cyc(1'b1, pc, call, ret, 1'b0, '0, '0, 1'b0, 1'b1, exp_npc, exp_src, req);
    endtask

    task automatic update(input logic [31:0] pc, input logic [31:0] tgt, input logic tk);
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, pc, tgt, tk, 1'b0, '0, 2'd0, "");
    endtask

    task automatic t_reset();
        fetch(32'h1000, 1'b0, 1'b0, 32'h1004, 2'd0, "R1");
        fetch(32'h2000, 1'b0, 1'b1, 32'h2004, 2'd0, "R1");
    endtask

    task automatic t_table();
        // R11: same-cycle install and lookup of the same slot
        cyc(1'b1, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h1000, 32'h3000, 1'b1,
            1'b1, 32'h1004, 2'd0, "R11");
        fetch(32'h1000, 1'b0, 1'b0, 32'h3000, 2'd1, "R3");
        fetch(32'h1100, 1'b0, 1'b0, 32'h1104, 2'd0, "R4");
        fetch(32'h1200, 1'b0, 1'b0, 32'h1204, 2'd0, "R2");
        update(32'h1100, 32'h5000, 1'b1);
        fetch(32'h1100, 1'b0, 1'b0, 32'h5000, 2'd1, "R5");
        fetch(32'h1000, 1'b0, 1'b0, 32'h1004, 2'd0, "R5");
    endtask

    task automatic t_not_taken();
        update(32'h1000, 32'h0, 1'b0);
        fetch(32'h1100, 1'b0, 1'b0, 32'h5000, 2'd1, "R6");
        update(32'h1100, 32'h0, 1'b0);
        fetch(32'h1100, 1'b0, 1'b0, 32'h1104, 2'd0, "R6");
    endtask

    task automatic t_call_ret();
        update(32'h2040, 32'h8000, 1'b1);
        update(32'h7100, 32'hA0000, 1'b1);
        fetch(32'h2040, 1'b1, 1'b0, 32'h8000, 2'd1, "R8");
        fetch(32'h9000, 1'b1, 1'b0, 32'h9004, 2'd0, "R8");
        fetch(32'h7000, 1'b0, 1'b1, 32'h9004, 2'd2, "R7");
        fetch(32'h7100, 1'b0, 1'b1, 32'h2044, 2'd2, "R7");
        fetch(32'h7100, 1'b0, 1'b1, 32'h7104, 2'd0, "R10");
        fetch(32'h7100, 1'b0, 1'b0, 32'hA0000, 2'd1, "R3");
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 9; k++)
            fetch(32'h4000 + 32'(16 * k), 1'b1, 1'b0, 32'h4004 + 32'(16 * k), 2'd0, "R9");
        for (int j = 0; j < 8; j++)
            fetch(32'h5800, 1'b0, 1'b1, 32'h4004 + 32'(16 * (8 - j)), 2'd2, "R9");
        fetch(32'h5800, 1'b0, 1'b1, 32'h5804, 2'd0, "R9");
    endtask

    task automatic t_idle_flags();
        fetch(32'h6000, 1'b1, 1'b0, 32'h6004, 2'd0, "R8");
        cyc(1'b0, 32'h6100, 1'b0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0, '0, 2'd0, "");
        cyc(1'b0, 32'h6200, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, 2'd0, "");
        fetch(32'h6300, 1'b0, 1'b1, 32'h6004, 2'd2, "R13");
        fetch(32'h6300, 1'b0, 1'b1, 32'h6304, 2'd0, "R13");
    endtask

    task automatic t_call_and_ret();
        fetch(32'h6300, 1'b1, 1'b0, 32'h6304, 2'd0, "R8");
        fetch(32'h6400, 1'b1, 1'b1, 32'h6304, 2'd2, "R12");
        fetch(32'h6500, 1'b0, 1'b1, 32'h6504, 2'd0, "R12");
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_table();
                t_not_taken();
                t_call_ret();
                t_overflow();
                t_idle_flags();
                t_call_and_ret();
                @(negedge clk);
                idle_inputs();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule